// File: doc/BRIEF.md
# Service-Pulse Watchdog Supervisor

The block watches a processor through a single service line. A timeout counter runs on the system clock. Three events clear it: a qualified edge on the service line, a suspend pulse, or any change of the active-low alarm output. If the counter reaches the selected timeout first, the block drops the alarm line for a bounded time. It then raises the line again and starts a new period from that edge. Left alone, the block therefore produces a steady alarm waveform that can drive a processor reset.

Both the service and suspend inputs are asynchronous. Each goes through a two-stage synchronizer and then a minimum-width filter before the block acts on it. Two variants are selected by a parameter. The dual-edge variant accepts both service edges and drives a fixed-width alarm pulse that service activity cannot shorten. The single-edge variant accepts only rising service edges, and a late service edge may end its alarm pulse early. Every duration is a parameter counted in clock cycles. The defaults are derived from a cycles-per-microsecond constant.

Top module: `wdg_supervisor`

## Requirements
- R1: During reset and right after it, `alarm_n_o` is high. The first alarm falls exactly TO[sel] cycles after the last reset cycle, with `tsel_i` sampled during reset.
- R2: `tsel_i` values 0, 1, 2 and 3 select timeouts TO0, TO1, TO2 and TO3. The select is captured only when the counter clears, so a change inside a period takes effect from the next clear.
- R3: A service rising edge that passes the filter clears the counter while the alarm is high. The clear acts 3+QUAL cycles after the edge at the pin.
- R4: A falling service edge clears the counter in the dual-edge variant (`DUAL_EDGE`=1) and has no effect in the single-edge variant.
- R5: A service level is accepted only once the synchronized level has differed from the filtered level for QUAL consecutive cycles. A pulse of QUAL-1 cycles is discarded, and a pulse of exactly QUAL cycles counts.
- R6: Every alarm transition restarts the counter. With no service activity, each high phase lasts exactly TO[sel] cycles.
- R7: In the dual-edge variant, each low phase lasts exactly PW cycles, and service edges during it are ignored.
- R8: In the single-edge variant, with no service activity, a low phase lasts TO[sel] cycles. A rising service edge seen during the low phase ends it at the later of that edge's clear point and MIN_LOW cycles after the fall.
- R9: While the filtered `suspend_i` is high (high means suspended), the counter is held at zero and `alarm_n_o` is forced high, which also ends a low phase. Both the onset and the release act 3+QUAL cycles after the pin changes.
- R10: A suspend pulse of at least QUAL cycles restarts the period from its release. A suspend glitch shorter than QUAL has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; release marks supply start-up |
| svc_i | input | 1 | Asynchronous service line from the supervised processor |
| suspend_i | input | 1 | Asynchronous suspend line; high suspends, low (idle) supervises |
| tsel_i | input | 2 | Timeout select, code 0..3 picks TO0..TO3 |
| alarm_n_o | output | 1 | Active-low alarm |

## Verification
The properties assume parameters with MIN_LOW no larger than any timeout, PW of at least one cycle, and a filter width of at least one cycle. They also assume that `tsel_i` changes only as a plain level with no timing tie to the counter. The stimulus changes inputs only on the falling clock edge. Service and suspend pulses are either held clearly above the filter width or kept one cycle below it, so each edge is accepted or rejected without ambiguity. Every service or suspend event is placed a known number of cycles after an observed alarm edge, which lets the expected phase lengths be derived from the stated latencies.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic {
        WD_ARMED = 1'b0,
        WD_ALARM = 1'b1
    } wd_state_e;

    // filtered view of one asynchronous input
    typedef struct packed {
        logic lvl;
        logic rose;
        logic fell;
    } qual_sig_t;

    function automatic int unsigned pick_limit(
        input logic [1:0]  sel,
        input int unsigned t0,
        input int unsigned t1,
        input int unsigned t2,
        input int unsigned t3
    );
        case (sel)
            2'd0:    return t0;
            2'd1:    return t1;
            2'd2:    return t2;
            default: return t3;
        endcase
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/wdg_pulse_qual.sv
module wdg_pulse_qual
    import wdg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_CYC    = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din_i,
    output qual_sig_t q_o
);
    localparam int unsigned RUN_W = bits_for(QUAL_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [RUN_W-1:0]       run_q;
    logic                   samp;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], din_i};
    end

    assign samp = sync_q[SYNC_STAGES-1];

    // a new level is accepted after QUAL_CYC consecutive mismatching samples
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            q_o   <= '0;
        end else begin
            q_o.rose <= 1'b0;
            q_o.fell <= 1'b0;
            if (samp != q_o.lvl) begin
                if (run_q == RUN_W'(QUAL_CYC - 1)) begin
                    q_o.lvl  <= samp;
                    q_o.rose <= samp;
                    q_o.fell <= ~samp;
                    run_q    <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/wdg_timeout_core.sv
module wdg_timeout_core
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter bit          DUAL_EDGE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             suspend,
    input  logic             svc_rose,
    input  logic             svc_fell,
    input  logic [1:0]       tsel_i,
    input  logic             at_lim,
    input  logic             at_pw,
    input  logic             min_low_ok,
    output logic [CNT_W-1:0] cnt_o,
    output logic [1:0]       sel_o,
    output wd_state_e        state_o
);
    logic svc_clear;
    logic alarm_done;
    logic seen_q;

    always_comb begin
        svc_clear = svc_rose | (DUAL_EDGE & svc_fell);
        if (DUAL_EDGE) alarm_done = at_pw;
        else           alarm_done = at_lim | (min_low_ok & (seen_q | svc_rose));
    end

    always_ff @(posedge clk) begin
        if (rst || suspend) begin
            state_o <= WD_ARMED;
            cnt_o   <= '0;
            sel_o   <= tsel_i;
            seen_q  <= 1'b0;
        end else begin
            case (state_o)
                WD_ARMED: begin
                    if (svc_clear) begin
                        cnt_o <= '0;
                        sel_o <= tsel_i;
                    end else if (at_lim) begin
                        state_o <= WD_ALARM;
                        cnt_o   <= '0;
                        sel_o   <= tsel_i;
                        seen_q  <= 1'b0;
                    end else begin
                        cnt_o <= cnt_o + 1'b1;
                    end
                end
                WD_ALARM: begin
                    if (alarm_done) begin
                        state_o <= WD_ARMED;
                        cnt_o   <= '0;
                        sel_o   <= tsel_i;
                        seen_q  <= 1'b0;
                    end else begin
                        cnt_o <= cnt_o + 1'b1;
                        if (svc_rose) seen_q <= 1'b1;
                    end
                end
                default: state_o <= WD_ARMED;
            endcase
        end
    end
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
    import wdg_pkg::*;
#(
    parameter int unsigned CYC_PER_US  = 250,
    parameter int unsigned TO0         = 3400 * CYC_PER_US,
    parameter int unsigned TO1         = 6300 * CYC_PER_US,
    parameter int unsigned TO2         = 102000 * CYC_PER_US,
    parameter int unsigned TO3         = 1600000 * CYC_PER_US,
    parameter int unsigned PW_CYC      = 10 * CYC_PER_US,
    parameter int unsigned MIN_LOW_CYC = 10 * CYC_PER_US,
    parameter int unsigned QUAL_CYC    = CYC_PER_US,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          DUAL_EDGE   = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       svc_i,
    input  logic       suspend_i,
    input  logic [1:0] tsel_i,
    output logic       alarm_n_o
);
    localparam int unsigned TO_MAX = max_of(max_of(TO0, TO1), max_of(TO2, TO3));
    localparam int unsigned SPAN   = max_of(TO_MAX, max_of(PW_CYC, MIN_LOW_CYC));
    localparam int unsigned CNT_W  = bits_for(SPAN);
    localparam int unsigned N_IN   = 2;

    logic [N_IN-1:0] raw_in;
    qual_sig_t       q_sig [N_IN];

    logic             suspend_act;
    logic [CNT_W-1:0] tmr_cnt;
    logic [CNT_W-1:0] tmr_lim;
    logic [1:0]       tmr_sel;
    wd_state_e        tmr_state;
    logic             at_lim, at_pw, min_low_ok;

    assign raw_in = {suspend_i, svc_i};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        wdg_pulse_qual #(
            .SYNC_STAGES(SYNC_STAGES),
            .QUAL_CYC   (QUAL_CYC)
        ) u_qual (
            .clk  (clk),
            .rst  (rst),
            .din_i(raw_in[gi]),
            .q_o  (q_sig[gi])
        );
    end

    // suspension holds through the cycle of its release pulse, matching the service latency
    assign suspend_act = q_sig[1].lvl | q_sig[1].rose | q_sig[1].fell;

    assign tmr_lim    = CNT_W'(pick_limit(tmr_sel, TO0, TO1, TO2, TO3));
    assign at_lim     = (tmr_cnt == tmr_lim - 1'b1);
    assign at_pw      = (tmr_cnt == CNT_W'(PW_CYC - 1));
    assign min_low_ok = (tmr_cnt >= CNT_W'(MIN_LOW_CYC - 1));

    wdg_timeout_core #(
        .CNT_W    (CNT_W),
        .DUAL_EDGE(DUAL_EDGE)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .suspend   (suspend_act),
        .svc_rose  (q_sig[0].rose),
        .svc_fell  (q_sig[0].fell),
        .tsel_i    (tsel_i),
        .at_lim    (at_lim),
        .at_pw     (at_pw),
        .min_low_ok(min_low_ok),
        .cnt_o     (tmr_cnt),
        .sel_o     (tmr_sel),
        .state_o   (tmr_state)
    );

    assign alarm_n_o = (tmr_state == WD_ARMED);
endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk #(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned PW_CYC      = 12,
    parameter int unsigned MIN_LOW_CYC = 16,
    parameter int unsigned TO_MAX      = 160,
    parameter bit          DUAL_EDGE   = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             alarm_n,
    input logic             susp,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim,
    input logic [1:0]       sel_q
);
    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (rst)           low_run <= 0;
        else if (!alarm_n) low_run <= low_run + 1;
        else               low_run <= 0;
    end

    AST_SUSPEND_IDLE: assert property (@(posedge clk) disable iff (rst)
        susp |=> (alarm_n && cnt == '0));                                   // R9

    AST_SEL_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(sel_q));                                    // R2

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        alarm_n |-> (cnt < lim));                                           // R6

    AST_FALL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm_n) |-> (($past(cnt) + 1'b1) == $past(lim)));            // R6

    if (DUAL_EDGE) begin : g_dual
        AST_FIXED_PULSE: assert property (@(posedge clk) disable iff (rst)
            low_run <= PW_CYC);                                             // R7
        AST_PULSE_FULL: assert property (@(posedge clk) disable iff (rst)
            ($rose(alarm_n) && !$past(susp)) |-> (low_run == PW_CYC));      // R7
    end else begin : g_single
        AST_PULSE_MIN: assert property (@(posedge clk) disable iff (rst)
            ($rose(alarm_n) && !$past(susp)) |-> (low_run >= MIN_LOW_CYC)); // R8
        AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst)
            low_run <= TO_MAX);                                             // R8
    end
endmodule

bind wdg_supervisor wdg_supervisor_chk #(
    .CNT_W      (CNT_W),
    .PW_CYC     (PW_CYC),
    .MIN_LOW_CYC(MIN_LOW_CYC),
    .TO_MAX     (TO_MAX),
    .DUAL_EDGE  (DUAL_EDGE)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .alarm_n(alarm_n_o),
    .susp   (suspend_act),
    .cnt    (tmr_cnt),
    .lim    (tmr_lim),
    .sel_q  (tmr_sel)
);

// File: tb/wdg_supervisor_bench.sv
module wdg_supervisor_bench;
    localparam int T0 = 40, T1 = 64, T2 = 96, T3 = 160;
    localparam int PW = 12, ML = 16, Q = 4;
    localparam int LAT = 3 + Q;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic svc_d = 1'b0, sus_d = 1'b0, svc_s = 1'b0, sus_s = 1'b0;
    logic [1:0] sel_d = 2'd0, sel_s = 2'd0;
    logic alm_d, alm_s;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        bit    lvl;
        int    len;
        int    stamp;
        string tag;
    } exp_t;

    exp_t q_d[$];
    exp_t q_s[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdg_supervisor #(
        .TO0(T0), .TO1(T1), .TO2(T2), .TO3(T3),
        .PW_CYC(PW), .MIN_LOW_CYC(ML), .QUAL_CYC(Q), .DUAL_EDGE(1'b1)
    ) u_wdg_supervisor (
        .clk(clk), .rst(rst), .svc_i(svc_d), .suspend_i(sus_d),
        .tsel_i(sel_d), .alarm_n_o(alm_d)
    );

    wdg_supervisor #(
        .TO0(T0), .TO1(T1), .TO2(T2), .TO3(T3),
        .PW_CYC(PW), .MIN_LOW_CYC(ML), .QUAL_CYC(Q), .DUAL_EDGE(1'b0)
    ) u_single (
        .clk(clk), .rst(rst), .svc_i(svc_s), .suspend_i(sus_s),
        .tsel_i(sel_s), .alarm_n_o(alm_s)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit alm(input int d);
        return (d == 0) ? alm_d : alm_s;
    endfunction

    // driver side of the scoreboard
    task automatic push(input int d, input bit lvl, input int len, input string tag);
        exp_t e;
        e.lvl = lvl; e.len = len; e.stamp = cyc; e.tag = tag;
        if (d == 0) q_d.push_back(e);
        else        q_s.push_back(e);
    endtask

    task automatic wait_to(input int d, input bit lvl, output int at);
        bit p;
        p = alm(d);
        forever begin
            @(negedge clk);
            if (alm(d) == lvl && p != lvl) break;
            p = alm(d);
        end
        at = cyc;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((q_d.size() != 0 || q_s.size() != 0) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(q_d.size() == 0 && q_s.size() == 0, "drain", q_d.size() + q_s.size(), 0);
    endtask

    // monitor side: measures each finished alarm phase and compares
    bit p_lvl [2];
    int seg_st [2];

    task automatic seg_done(input int d, input bit lvl, input int st, input int len);
        exp_t e;
        if (d == 0) begin
            if (q_d.size() == 0 || st < q_d[0].stamp) return;
            e = q_d.pop_front();
        end else begin
            if (q_s.size() == 0 || st < q_s[0].stamp) return;
            e = q_s.pop_front();
        end
        check(e.lvl == lvl && e.len == len, e.tag, lvl ? len : -len, e.lvl ? e.len : -e.len);
    endtask

    always @(negedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                p_lvl[d]  = alm(d);
                seg_st[d] = cyc;
            end else if (alm(d) != p_lvl[d]) begin
                seg_done(d, p_lvl[d], seg_st[d], cyc - seg_st[d]);
                p_lvl[d]  = alm(d);
                seg_st[d] = cyc;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int a, b, rel, k2, lows;
        // R1 reset state and first period
        repeat (5) @(negedge clk);
        check(alm_d == 1'b1, "R1 alarm high in reset", alm_d, 1);
        check(alm_s == 1'b1, "R1 alarm high in reset single", alm_s, 1);
        rst = 1'b0;
        rel = cyc;
        @(negedge clk);
        check(alm_d == 1'b1, "R1 alarm high after reset", alm_d, 1);
        fork
            wait_to(0, 1'b0, a);
            wait_to(1, 1'b0, b);
        join
        check(a - rel == T0, "R1 first timeout", a - rel, T0);
        check(b - rel == T0, "R1 first timeout single", b - rel, T0);

        // R6 R7 R8 free running
        push(0, 0, PW, "R7 dual pulse");
        push(0, 1, T0, "R6 dual high");
        push(0, 0, PW, "R7 dual pulse 2");
        push(0, 1, T0, "R6 dual high 2");
        push(1, 0, T0, "R8 single low");
        push(1, 1, T0, "R6 single high");
        push(1, 0, T0, "R8 single low 2");
        drain();

        // R2 select change mid period
        wait_to(0, 1'b1, a);
        push(0, 1, T0, "R2 current period kept");
        push(0, 0, PW, "R2 pulse");
        push(0, 1, T2, "R2 new period");
        repeat (10) @(negedge clk);
        sel_d = 2'd2;
        drain();

        // R3 rising service clear
        wait_to(0, 1'b1, a);
        push(0, 1, 20 + LAT + T2, "R3 rise clears");
        push(0, 0, PW, "R3 pulse");
        repeat (20) @(negedge clk);
        svc_d = 1'b1;
        drain();

        // R4 falling edge clears in dual variant
        wait_to(0, 1'b1, a);
        push(0, 1, 20 + LAT + T2, "R4 fall clears dual");
        push(0, 0, PW, "R4 pulse");
        repeat (20) @(negedge clk);
        svc_d = 1'b0;
        drain();

        // R5 glitch of Q-1 cycles rejected
        wait_to(0, 1'b1, a);
        push(0, 1, T2, "R5 glitch rejected");
        push(0, 0, PW, "R5 pulse");
        repeat (20) @(negedge clk);
        svc_d = 1'b1;
        repeat (Q - 1) @(negedge clk);
        svc_d = 1'b0;
        drain();

        // R7 service during the pulse is ignored
        wait_to(0, 1'b0, a);
        push(0, 0, PW, "R7 pulse ignores service");
        push(0, 1, T2, "R7 high after pulse");
        repeat (3) @(negedge clk);
        svc_d = 1'b1;
        drain();

        // R9 long suspend
        wait_to(0, 1'b1, a);
        repeat (10) @(negedge clk);
        sus_d = 1'b1;
        lows = 0;
        repeat (200) begin
            @(negedge clk);
            if (!alm_d) lows++;
        end
        check(lows == 0, "R9 alarm held high while suspended", lows, 0);
        sus_d = 1'b0;
        k2 = cyc;
        wait_to(0, 1'b0, a);
        check(a - k2 == T2 + LAT, "R9 release restarts period", a - k2, T2 + LAT);
        repeat (3) @(negedge clk);
        sus_d = 1'b1;
        wait_to(0, 1'b1, b);
        check(b - a == 3 + LAT, "R9 suspend ends pulse", b - a, 3 + LAT);
        repeat (10) @(negedge clk);
        sus_d = 1'b0;

        // R10 short suspend pulse restarts, glitch ignored
        wait_to(0, 1'b1, a);
        repeat (20) @(negedge clk);
        sus_d = 1'b1;
        repeat (Q + 2) @(negedge clk);
        sus_d = 1'b0;
        k2 = cyc;
        wait_to(0, 1'b0, a);
        check(a - k2 == T2 + LAT, "R10 suspend pulse restarts", a - k2, T2 + LAT);
        wait_to(0, 1'b1, a);
        push(0, 1, T2, "R10 suspend glitch ignored");
        push(0, 0, PW, "R10 pulse");
        repeat (20) @(negedge clk);
        sus_d = 1'b1;
        repeat (Q - 1) @(negedge clk);
        sus_d = 1'b0;
        drain();

        // single-edge variant: R3 rise clears, R4 fall ignored
        wait_to(1, 1'b1, a);
        push(1, 1, 20 + LAT + T0, "R3 rise clears single");
        push(1, 0, T0, "R3 single low");
        repeat (20) @(negedge clk);
        svc_s = 1'b1;
        drain();
        wait_to(1, 1'b1, a);
        push(1, 1, T0, "R4 fall ignored single");
        push(1, 0, T0, "R4 single low");
        repeat (20) @(negedge clk);
        svc_s = 1'b0;
        drain();

        // R5 pulse of exactly Q cycles accepted
        wait_to(1, 1'b1, a);
        push(1, 1, 20 + LAT + T0, "R5 Q-cycle pulse accepted");
        push(1, 0, T0, "R5 single low");
        repeat (20) @(negedge clk);
        svc_s = 1'b1;
        repeat (Q) @(negedge clk);
        svc_s = 1'b0;
        drain();

        // R8 early service during pulse ends at MIN_LOW
        wait_to(1, 1'b0, a);
        push(1, 0, ML, "R8 early service waits for minimum");
        push(1, 1, T0, "R8 high after early end");
        svc_s = 1'b1;
        repeat (8) @(negedge clk);
        svc_s = 1'b0;
        drain();

        // R8 late service ends pulse at its clear point
        wait_to(1, 1'b0, a);
        push(1, 0, 10 + LAT, "R8 late service ends pulse");
        push(1, 1, T0, "R8 high after late end");
        repeat (10) @(negedge clk);
        svc_s = 1'b1;
        drain();

        // R2 codes 3 and 1
        wait_to(1, 1'b1, a);
        push(1, 1, T0, "R2 single current kept");
        push(1, 0, T3, "R2 code 3 low");
        push(1, 1, T3, "R2 code 3 high");
        repeat (5) @(negedge clk);
        sel_s = 2'd3;
        drain();
        sel_s = 2'd1;
        wait_to(1, 1'b1, a);
        push(1, 1, T1, "R2 code 1 high");
        push(1, 0, T1, "R2 code 1 low");
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule